// File: doc/BRIEF.md
# USB Pipe Buffer-Ready Interrupt Controller

This block follows the ownership of the single packet buffer behind one USB endpoint pipe and raises a sticky buffer-ready flag for that pipe. A simplified packet engine feeds it with events: a data packet received with its byte count, a data packet sent, and a handshake acknowledge. The CPU side reports when it has drained or refilled the buffer. The buffer is modelled only as ownership. It belongs either to the USB side, which may receive or transmit, or to the CPU side, which may read or write.

Configuration inputs select the pipe direction, the maximum packet size and isochronous operation. They also select an end-of-transfer mode and a transaction count. In the end-of-transfer mode a received packet still hands the buffer to the CPU, but the ready flag waits until the transfer is over. A transfer is over after a short packet, or once the programmed number of packets has arrived. The interrupt line is the flag gated by a per-pipe enable. A reconfiguration pulse restarts the pipe.

Top module: `usbp_brdy_ctrl`

## Requirements
- R1: After reset the buffer is USB-owned (`buf_cpu_o`=0), and `rdy_o` and `irq_o` are 0.
- R2: With end-of-transfer mode off on a receive pipe, a committed received packet of any length, zero included, makes `buf_cpu_o`=1 and `rdy_o`=1 on the next cycle.
- R3: With end-of-transfer mode on, a committed received packet that does not end the transfer makes `buf_cpu_o`=1 and leaves `rdy_o` unchanged.
- R4: In end-of-transfer mode, a received packet shorter than `cfg_mps_i`, zero bytes included, ends the transfer and sets `rdy_o`.
- R5: In end-of-transfer mode, when `cfg_trn_cnt_i` is nonzero, the packet that brings the received count up to `cfg_trn_cnt_i` ends the transfer and sets `rdy_o`. A count of 0 disables this condition. The packet count returns to zero at every end of transfer.
- R6: On a transmit pipe (`cfg_dir_tx_i`=1), a committed sent packet returns the buffer to the CPU (`buf_cpu_o`=1) and sets `rdy_o`.
- R7: With `cfg_iso_i`=0, a packet commits only on a later `ack_i` pulse. With `cfg_iso_i`=1, it commits in the cycle of the packet pulse and `ack_i` is ignored.
- R8: While the CPU owns the buffer, packet and acknowledge pulses have no effect. A `cpu_done_i` pulse returns ownership to the USB side.
- R9: `rdy_o` stays set until a `rdy_clr_i` pulse clears it. If a clear and a set fall in the same cycle, the flag ends up set.
- R10: `irq_o` is 1 exactly when `rdy_o` and `irq_en_i` are both 1.
- R11: A `cfg_load_i` pulse clears the packet count and drops an unacknowledged packet. It makes the buffer USB-owned on a receive pipe and CPU-owned on a transmit pipe, and leaves `rdy_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dir_tx_i | input | 1 | 1 = transmit pipe, 0 = receive pipe |
| cfg_iso_i | input | 1 | 1 = isochronous, no handshake wait |
| cfg_eot_mode_i | input | 1 | Hold the ready flag until end of transfer |
| cfg_mps_i | input | LEN_W | Maximum packet size in bytes |
| cfg_trn_cnt_i | input | TRN_W | Packets per transfer, 0 = no count limit |
| cfg_load_i | input | 1 | Reconfiguration pulse |
| rx_pkt_i | input | 1 | Data packet received |
| rx_len_i | input | LEN_W | Byte count of the received packet |
| tx_pkt_i | input | 1 | Data packet sent |
| ack_i | input | 1 | Handshake acknowledge for the last packet |
| cpu_done_i | input | 1 | CPU has drained or filled the buffer |
| rdy_clr_i | input | 1 | Write-one-to-clear for the ready flag |
| irq_en_i | input | 1 | Interrupt enable for this pipe |
| buf_cpu_o | output | 1 | 1 = buffer owned by the CPU side |
| rdy_o | output | 1 | Sticky buffer-ready flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the end-of-transfer cases. A full-size packet before the count is reached must not raise the flag, while a zero-length packet must. A design that compares packet length with the wrong relation, or counts one packet too many or too few, raises the flag on the wrong packet. The bench clears the count through reconfiguration in the middle of a transfer; stale state would end the next transfer early. The bench also collides a clear with a set, which must keep the flag, and sends packets while the CPU owns the buffer, which must not re-arm the buffer. It sends a non-isochronous packet without an acknowledge, which must not move ownership; an early commit would hand over a buffer still being handshaken.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  typedef enum logic {
    OWN_USB = 1'b0,
    OWN_CPU = 1'b1
  } own_e;
endpackage

// File: rtl/usbp_buf_fsm.sv
module usbp_buf_fsm
  import usbp_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_tx_i,
  input  logic             iso_i,
  input  logic             load_i,
  input  logic             rx_pkt_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             tx_pkt_i,
  input  logic             ack_i,
  input  logic             cpu_done_i,
  output logic             commit_o,
  output logic [LEN_W-1:0] commit_len_o,
  output own_e             own_o
);
  own_e             own_q, own_d;
  logic             pend_q, pend_d;
  logic [LEN_W-1:0] plen_q, plen_d;
  logic             pkt, accept;

  assign pkt    = dir_tx_i ? tx_pkt_i : rx_pkt_i;
  assign accept = !load_i && (own_q == OWN_USB) && !pend_q && pkt;

  always_comb begin
    commit_o     = 1'b0;
    commit_len_o = rx_len_i;
    pend_d       = pend_q;
    plen_d       = plen_q;
    own_d        = own_q;
    if (load_i) begin
      pend_d = 1'b0;
      own_d  = dir_tx_i ? OWN_CPU : OWN_USB;
    end else begin
      if (iso_i) begin
        commit_o = accept;
      end else if (pend_q && ack_i) begin
        commit_o     = 1'b1;
        commit_len_o = plen_q;
        pend_d       = 1'b0;
      end else if (accept) begin
        pend_d = 1'b1;
        plen_d = rx_len_i;
      end
      if (commit_o) own_d = OWN_CPU;
      else if (own_q == OWN_CPU && cpu_done_i) own_d = OWN_USB;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= OWN_USB;
      pend_q <= 1'b0;
      plen_q <= '0;
    end else begin
      own_q  <= own_d;
      pend_q <= pend_d;
      plen_q <= plen_d;
    end
  end

  assign own_o = own_q;

  p_ack_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_i && !load_i && own_q == OWN_USB && !pend_q && pkt) |=> (own_q == OWN_USB));
  p_cpu_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_CPU && !cpu_done_i && !load_i) |=> (own_q == OWN_CPU));
endmodule

// File: rtl/usbp_xfer_end.sv
module usbp_xfer_end #(
  parameter int LEN_W = 10,
  parameter int TRN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             rx_commit_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] mps_i,
  input  logic [TRN_W-1:0] trn_cnt_i,
  output logic             end_o
);
  logic [TRN_W-1:0] cnt_q;
  logic [TRN_W:0]   cnt_inc;
  logic             short_pkt, cnt_hit;

  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign short_pkt = len_i < mps_i;
  assign cnt_hit   = (trn_cnt_i != '0) && (cnt_inc == {1'b0, trn_cnt_i});
  assign end_o     = short_pkt || cnt_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= '0;
    else if (rx_commit_i) cnt_q <= end_o ? '0 : cnt_inc[TRN_W-1:0];
  end

  p_cnt_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));
  p_cnt_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && rx_commit_i && end_o) |=> (cnt_q == '0));
endmodule

// File: rtl/usbp_rdy_flag.sv
module usbp_rdy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/usbp_brdy_ctrl.sv
module usbp_brdy_ctrl
  import usbp_pkg::*;
#(
  parameter int MAX_MPS = 512,
  parameter int TRN_W   = 8,
  localparam int LEN_W  = $clog2(MAX_MPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_dir_tx_i,
  input  logic             cfg_iso_i,
  input  logic             cfg_eot_mode_i,
  input  logic [LEN_W-1:0] cfg_mps_i,
  input  logic [TRN_W-1:0] cfg_trn_cnt_i,
  input  logic             cfg_load_i,
  input  logic             rx_pkt_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             tx_pkt_i,
  input  logic             ack_i,
  input  logic             cpu_done_i,
  input  logic             rdy_clr_i,
  input  logic             irq_en_i,
  output logic             buf_cpu_o,
  output logic             rdy_o,
  output logic             irq_o
);
  own_e             own;
  logic             commit, rx_commit, xfer_end, rdy_set;
  logic [LEN_W-1:0] commit_len;

  usbp_buf_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i, .rst_ni,
    .dir_tx_i     (cfg_dir_tx_i),
    .iso_i        (cfg_iso_i),
    .load_i       (cfg_load_i),
    .rx_pkt_i, .rx_len_i, .tx_pkt_i, .ack_i, .cpu_done_i,
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .own_o        (own)
  );

  assign rx_commit = commit && !cfg_dir_tx_i;

  usbp_xfer_end #(.LEN_W(LEN_W), .TRN_W(TRN_W)) u_end (
    .clk_i, .rst_ni,
    .load_i      (cfg_load_i),
    .rx_commit_i (rx_commit),
    .len_i       (commit_len),
    .mps_i       (cfg_mps_i),
    .trn_cnt_i   (cfg_trn_cnt_i),
    .end_o       (xfer_end)
  );

  // transmit and plain receive flag at once; end-of-transfer mode waits
  assign rdy_set = commit && (cfg_dir_tx_i || !cfg_eot_mode_i || xfer_end);

  usbp_rdy_flag u_flag (
    .clk_i, .rst_ni,
    .set_i  (rdy_set),
    .clr_i  (rdy_clr_i),
    .flag_o (rdy_o)
  );

  assign buf_cpu_o = (own == OWN_CPU);
  assign irq_o     = rdy_o && irq_en_i;

  p_handover_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(buf_cpu_o) && !$past(cfg_load_i) &&
     !($past(cfg_eot_mode_i) && !$past(cfg_dir_tx_i))) |-> rdy_o);
  p_load_keeps_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_i && rdy_o && !rdy_clr_i) |=> rdy_o);
endmodule

// File: tb/sim_usbp_brdy_ctrl.sv
module sim_usbp_brdy_ctrl;
  localparam int MAX_MPS = 512;
  localparam int TRN_W   = 8;
  localparam int LEN_W   = $clog2(MAX_MPS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_tx = 0, iso = 0, eot = 0, load = 0;
  logic [LEN_W-1:0] mps = 64, rx_len = 0;
  logic [TRN_W-1:0] trn = 0;
  logic rx_pkt = 0, tx_pkt = 0, ack = 0, cpu_done = 0, clr = 0, en = 0;
  logic buf_cpu, rdy, irq;

  int vecs = 0, errs = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  usbp_brdy_ctrl #(.MAX_MPS(MAX_MPS), .TRN_W(TRN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_dir_tx_i(dir_tx), .cfg_iso_i(iso), .cfg_eot_mode_i(eot),
    .cfg_mps_i(mps), .cfg_trn_cnt_i(trn), .cfg_load_i(load),
    .rx_pkt_i(rx_pkt), .rx_len_i(rx_len), .tx_pkt_i(tx_pkt), .ack_i(ack),
    .cpu_done_i(cpu_done), .rdy_clr_i(clr), .irq_en_i(en),
    .buf_cpu_o(buf_cpu), .rdy_o(rdy), .irq_o(irq)
  );

  // behavioural reference model
  int m_own = 0, m_pend = 0, m_plen = 0, m_cnt = 0, m_flag = 0;

  task automatic cmp(string req, int act, int exp, string what);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int commit, clen, set, pkt, fin;
      commit = 0; clen = 0; set = 0;
      pkt = dir_tx ? tx_pkt : rx_pkt;
      if (load) begin
        m_own = dir_tx; m_pend = 0; m_cnt = 0;
      end else begin
        if (iso) begin
          if (m_own == 0 && !m_pend && pkt) begin commit = 1; clen = rx_len; end
        end else if (m_pend && ack) begin
          commit = 1; clen = m_plen; m_pend = 0;
        end else if (m_own == 0 && !m_pend && pkt) begin
          m_pend = 1; m_plen = rx_len;
        end
        if (commit) begin
          m_own = 1;
          if (dir_tx) set = 1;
          else begin
            fin = (clen < mps) || (trn != 0 && m_cnt + 1 == trn);
            m_cnt = fin ? 0 : m_cnt + 1;
            set = !eot || fin;
          end
        end else if (m_own == 1 && cpu_done) m_own = 0;
      end
      if (set) m_flag = 1; else if (clr) m_flag = 0;
    end
    #1;
    if (!done) begin
      cmp(cur_req, buf_cpu, m_own, "buf_cpu_o");
      cmp(cur_req, rdy, m_flag, "rdy_o");
      cmp("R10", irq, m_flag & en, "irq_o");
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_send(int len, bit with_ack);
    rx_pkt = 1; rx_len = len[LEN_W-1:0]; cyc(); rx_pkt = 0;
    if (with_ack && !iso) begin ack = 1; cyc(); ack = 0; end
    cyc();
  endtask

  task automatic pulse_done(); cpu_done = 1; cyc(); cpu_done = 0; cyc(); endtask
  task automatic pulse_clr();  clr = 1; cyc(); clr = 0; cyc(); endtask
  task automatic pulse_load(); load = 1; cyc(); load = 0; cyc(); endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    cyc(2);
    cmp("R1", buf_cpu, 0, "reset buf_cpu_o");
    cmp("R1", rdy, 0, "reset rdy_o");
    rst_n = 1; cyc(2);

    cur_req = "R2"; en = 1;
    rx_send(64, 1);
    cmp("R2", rdy, 1, "full packet flag");
    pulse_clr(); pulse_done();
    rx_send(0, 1);
    cmp("R2", rdy, 1, "zero-length flag");
    cmp("R2", buf_cpu, 1, "zero-length ownership");

    cur_req = "R8"; pulse_clr();
    rx_send(64, 1);
    cmp("R8", rdy, 0, "packet while CPU owns");
    pulse_done();
    cmp("R8", buf_cpu, 0, "cpu_done returns buffer");

    cur_req = "R3"; eot = 1;
    rx_send(64, 1); cmp("R3", rdy, 0, "full packet held");
    cmp("R3", buf_cpu, 1, "full packet readable");
    pulse_done(); rx_send(64, 1); cmp("R3", rdy, 0, "second full held");
    cur_req = "R4"; pulse_done();
    rx_send(10, 1); cmp("R4", rdy, 1, "short packet ends");
    pulse_clr(); pulse_done();
    rx_send(0, 1); cmp("R4", rdy, 1, "zero-length ends");
    pulse_clr(); pulse_done();
    rx_send(63, 1); cmp("R4", rdy, 1, "mps-1 ends");
    pulse_clr(); pulse_done();

    cur_req = "R5"; trn = 3;
    for (int i = 0; i < 3; i++) begin
      rx_send(64, 1);
      cmp("R5", rdy, (i == 2) ? 1 : 0, "count end");
      pulse_done();
    end
    pulse_clr();
    rx_send(64, 1); cmp("R5", rdy, 0, "count restarted");
    pulse_done();
    trn = 0; pulse_load();
    for (int i = 0; i < 4; i++) begin
      rx_send(64, 1); cmp("R5", rdy, 0, "count zero disabled"); pulse_done();
    end

    cur_req = "R11"; trn = 3; pulse_load();
    rx_send(64, 1); pulse_done(); rx_send(64, 1); pulse_done();
    pulse_load();
    rx_send(64, 1); pulse_done(); rx_send(64, 1);
    cmp("R11", rdy, 0, "count cleared by load");
    pulse_done(); rx_send(64, 1);
    cmp("R11", rdy, 1, "third after load ends");
    pulse_done();
    rx_pkt = 1; rx_len = 64; cyc(); rx_pkt = 0; cyc();
    pulse_load(); ack = 1; cyc(); ack = 0; cyc();
    cmp("R11", buf_cpu, 0, "pending dropped on load");

    cur_req = "R6"; eot = 0; pulse_clr(); dir_tx = 1; pulse_load();
    cmp("R11", buf_cpu, 1, "tx load gives CPU");
    cmp("R11", rdy, 0, "load sets no flag");
    pulse_done();
    tx_pkt = 1; cyc(); tx_pkt = 0; cyc(2);
    cmp("R7", buf_cpu, 0, "tx waits ack");
    ack = 1; cyc(); ack = 0; cyc();
    cmp("R6", buf_cpu, 1, "tx sent writable");
    cmp("R6", rdy, 1, "tx flag");

    cur_req = "R7"; pulse_clr(); pulse_done();
    iso = 1;
    tx_pkt = 1; cyc(); tx_pkt = 0; cyc();
    cmp("R7", buf_cpu, 1, "iso immediate");
    cmp("R7", rdy, 1, "iso flag");
    dir_tx = 0; pulse_load(); pulse_clr();
    ack = 1; cyc(); ack = 0; cyc();
    cmp("R7", buf_cpu, 0, "iso ack ignored");
    rx_send(5, 0); cmp("R7", rdy, 1, "iso rx");
    pulse_done(); iso = 0;

    cur_req = "R9";
    rx_send(64, 1); pulse_done();
    rx_pkt = 1; rx_len = 64; cyc(); rx_pkt = 0; ack = 1; clr = 1; cyc();
    ack = 0; clr = 0; cyc();
    cmp("R9", rdy, 1, "set beats clear");
    cyc(3); cmp("R9", rdy, 1, "flag sticky");
    pulse_clr(); cmp("R9", rdy, 0, "w1c");

    cur_req = "R10"; pulse_done(); rx_send(64, 1);
    en = 0; cyc(); cmp("R10", irq, 0, "masked");
    en = 1; cyc(); cmp("R10", irq, 1, "enabled");
    pulse_clr(); cmp("R10", irq, 0, "cleared");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule